// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Controller Pair

This block joins a bus master controller and a single addressed slave controller. The two controllers trade a request line and an acknowledge line under a four-phase protocol. Both sides are synchronous state machines. Each one passes the other side's handshake line through a two-flop synchronizer, so the two ends could run on unrelated clocks. A local agent hands the master one command at a time: a direction, an address and, for a write, a data word. The master places these on the bus and holds them for a set number of cycles so that the slave can decode the address. It then raises the request line.

The slave compares the upper address bits against its base and serves a small word store indexed by the lower bits. On a write, the slave's acknowledge means the word has been stored. On a read, the acknowledge means the read word is on the bus. The slave drives the read bus only while its acknowledge is high. When the master sees the acknowledge, it captures any read data and drops its request. The slave then drops its acknowledge. The master reports completion only after it has seen the acknowledge fall, and only then does it accept the next command.

Top module: `hsBus`

## Requirements
- R1: After reset, busReq, busAck, busRdOe and cmdDone are 0, cmdReady is 1, rdData is 0 and busRdData is 0.
- R2: A command is accepted on a rising edge where cmdValid and cmdReady are both 1. From the next cycle, busAddr, busWrite and busWdata carry the command's values. They stay unchanged while busReq or busAck is high.
- R3: busReq rises exactly DECODE_CYCLES clock cycles after the edge that accepts the command. DECODE_CYCLES is at least 1 and defaults to 3.
- R4: The slave responds only when busAddr[7:4] equals the upper nibble of BASE_ADDR (default 0xA). busAddr[3:0] selects one of 16 words. busAck rises only while busReq is high.
- R5: On a write (busWrite=1), the addressed word is stored by the time busAck rises. A later read of that address returns the stored word.
- R6: On a read (busWrite=0), busRdOe is 1 and busRdData holds the addressed word while busAck is high. Whenever busAck is low, busRdOe is 0 and busRdData is 0. The master copies the word to rdData and holds it until the next read.
- R7: busReq falls only while busAck is high. busAck falls only after busReq is low. busReq does not rise while busAck is high.
- R8: cmdDone pulses for one cycle after the master sees busAck low following its release of busReq. cmdReady is 0 from acceptance until that pulse.
- R9: A command to an address outside the slave's range gets no acknowledge. busReq stays high and cmdReady stays 0, with the command pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered by the local agent |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | 8 | Command address |
| cmdWdata | input | 16 | Write data |
| cmdReady | output | 1 | Master idle, command may be accepted |
| cmdDone | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last word captured by a read |
| busReq | output | 1 | Master request line |
| busAck | output | 1 | Slave acknowledge line |
| busAddr | output | 8 | Bus address held by the master |
| busWrite | output | 1 | Bus direction held by the master |
| busWdata | output | 16 | Bus write data held by the master |
| busRdData | output | 16 | Slave read data, zero when released |
| busRdOe | output | 1 | Slave driving the read data bus |

## Verification
The assertions check the protocol rules on every cycle:
- the ordering of edges on the request and acknowledge lines;
- that address and direction stay put while a handshake is open;
- that the read bus is released whenever the acknowledge is low;
- that the completion pulse lasts a single cycle.

Other behaviours can only be shown by the bench's scenarios, because they depend on history and on exact cycle counts. These are the settling delay measured from acceptance, the fact that a stored word comes back on a later read, boundary word indices, and a transfer to a foreign address that stays pending.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_SETTLE = 2'd1,
    M_WAIT   = 2'd2,
    M_REL    = 2'd3
  } mState_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_ACK  = 1'b1
  } sState_t;

  // strobes from master control to master datapath
  typedef struct packed {
    logic loadCmd;
    logic setReq;
    logic clrReq;
    logic capRd;
  } mStrobe_t;

endpackage

// File: rtl/hsSync.sv
module hsSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hsMasterCtrl.sv
module hsMasterCtrl
  import hs_pkg::*;
#(
  parameter int DECODE_CYCLES = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     ackSync,
  output mStrobe_t strobe,
  output logic     cmdReady,
  output logic     cmdDone
);
  localparam int CNT_W = (DECODE_CYCLES < 2) ? 1 : $clog2(DECODE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECODE_CYCLES - 1);

  mState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic doneD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    doneD  = 1'b0;
    strobe = '0;
    unique case (stateQ)
      M_IDLE: begin
        if (cmdValid) begin
          strobe.loadCmd = 1'b1;
          cntD   = '0;
          stateD = M_SETTLE;
        end
      end
      M_SETTLE: begin
        if (cntQ == CNT_LAST) begin
          strobe.setReq = 1'b1;
          stateD = M_WAIT;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      M_WAIT: begin
        if (ackSync) begin
          strobe.clrReq = 1'b1;
          strobe.capRd  = 1'b1;
          stateD = M_REL;
        end
      end
      M_REL: begin
        if (!ackSync) begin
          doneD  = 1'b1;
          stateD = M_IDLE;
        end
      end
      default: stateD = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= M_IDLE;
      cntQ    <= '0;
      cmdDone <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      cmdDone <= doneD;
    end
  end

  assign cmdReady = (stateQ == M_IDLE);
endmodule

// File: rtl/hsMasterPath.sv
module hsMasterPath
  import hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mStrobe_t          strobe,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [DATA_W-1:0] busRdData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReq   <= 1'b0;
      busAddr  <= '0;
      busWrite <= 1'b0;
      busWdata <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.loadCmd) begin
        busAddr  <= cmdAddr;
        busWrite <= cmdWrite;
        busWdata <= cmdWrite ? cmdWdata : '0;
      end
      if (strobe.setReq)      busReq <= 1'b1;
      else if (strobe.clrReq) busReq <= 1'b0;
      if (strobe.capRd && !busWrite) rdData <= busRdData;
    end
  end
endmodule

// File: rtl/hsSlave.sv
module hsSlave
  import hs_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              IDX_W     = 4,
  parameter int              SYNC_STGS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busAck,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdOe
);
  localparam int DEPTH = 1 << IDX_W;

  logic reqSync;
  sState_t stateQ;
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdHoldQ;
  logic hitQ;
  logic match;
  logic [IDX_W-1:0] idx;

  hsSync #(.STAGES(SYNC_STGS)) reqSync_i (
    .clk(clk), .rstN(rstN), .din(busReq), .dout(reqSync)
  );

  assign idx   = busAddr[IDX_W-1:0];
  assign match = (busAddr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      rdHoldQ <= '0;
      hitQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        S_IDLE: if (reqSync && match) begin
          stateQ  <= S_ACK;
          hitQ    <= !busWrite;
          rdHoldQ <= store[idx];
        end
        S_ACK: if (!reqSync) begin
          stateQ <= S_IDLE;
          hitQ   <= 1'b0;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) store[w] <= '0;
      else if (stateQ == S_IDLE && reqSync && match && busWrite &&
               idx == IDX_W'(w))
        store[w] <= busWdata;
    end
  end

  assign busAck    = (stateQ == S_ACK);
  assign busRdOe   = busAck && hitQ;
  assign busRdData = busRdOe ? rdHoldQ : '0;
endmodule

// File: rtl/hsBus.sv
module hsBus
  import hs_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter int              DATA_W        = 16,
  parameter int              IDX_W         = 4,
  parameter int              DECODE_CYCLES = 3,
  parameter int              SYNC_STGS     = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic              cmdReady,
  output logic              cmdDone,
  output logic [DATA_W-1:0] rdData,
  output logic              busReq,
  output logic              busAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdOe
);
  mStrobe_t strobe;
  logic ackSync;

  hsSync #(.STAGES(SYNC_STGS)) ackSync_i (
    .clk(clk), .rstN(rstN), .din(busAck), .dout(ackSync)
  );

  hsMasterCtrl #(.DECODE_CYCLES(DECODE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .ackSync(ackSync),
    .strobe(strobe), .cmdReady(cmdReady), .cmdDone(cmdDone)
  );

  hsMasterPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .busRdData(busRdData),
    .busReq(busReq), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .rdData(rdData)
  );

  hsSlave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
            .SYNC_STGS(SYNC_STGS), .BASE_ADDR(BASE_ADDR)) slave_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr),
    .busWrite(busWrite), .busWdata(busWdata), .busAck(busAck),
    .busRdData(busRdData), .busRdOe(busRdOe)
  );
endmodule

// File: rtl/hsBusChecker.sv
module hsBusChecker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              cmdDone,
  input logic              busReq,
  input logic              busAck,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [DATA_W-1:0] busRdData,
  input logic              busRdOe
);
  // R2: address and direction frozen while a handshake is open
  a_r2_bus_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq || busAck) |-> ($stable(busAddr) && $stable(busWrite)));

  // R4: acknowledge only rises in answer to a request
  a_r4_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> busReq);

  // R7: request drops only after acknowledge seen
  a_r7_req_fall_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(busAck));

  // R7: acknowledge drops only after request gone
  a_r7_ack_fall_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAck) |-> (!busReq && $past(!busReq)));

  // R7: no new request while acknowledge still high
  a_r7_no_req_during_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !busAck);

  // R6: read bus released while acknowledge low, stable while driven
  a_r6_rd_released: assert property (@(posedge clk) disable iff (!rstN)
    !busAck |-> (!busRdOe && busRdData == '0));

  a_r6_rd_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busRdOe && $past(busRdOe)) |-> $stable(busRdData));

  // R8: done is a single-cycle pulse and lands in the idle state
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> (cmdReady && !busReq && !busAck));
endmodule

bind hsBus hsBusChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .cmdDone(cmdDone),
  .busReq(busReq), .busAck(busAck), .busAddr(busAddr),
  .busWrite(busWrite), .busRdData(busRdData), .busRdOe(busRdOe)
);

// File: tb/hsBus_tb.sv
module hsBus_tb_top;
  localparam int DEC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdWrite = 1'b0;
  logic [7:0] cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic cmdReady, cmdDone, busReq, busAck, busWrite, busRdOe;
  logic [15:0] rdData, busWdata, busRdData;
  logic [7:0] busAddr;

  int checks = 0;
  int errors = 0;
  int protoViol = 0;
  int holdViol = 0;
  logic prevReq = 0, prevAck = 0;
  logic [7:0] prevAddr = '0;

  always #4 clk = ~clk;

  hsBus #(.DECODE_CYCLES(DEC)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdReady(cmdReady),
    .cmdDone(cmdDone), .rdData(rdData), .busReq(busReq), .busAck(busAck),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .busRdData(busRdData), .busRdOe(busRdOe)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // protocol monitor for R7 and R2 (bench-side)
  always @(negedge clk) begin
    if (rstN) begin
      if (prevReq && !busReq && !prevAck) protoViol++;
      if (prevAck && !busAck && busReq) protoViol++;
      if (!prevReq && busReq && busAck) protoViol++;
      if ((prevReq || prevAck) && (busReq || busAck) && busAddr !== prevAddr)
        holdViol++;
    end
    prevReq  = busReq;
    prevAck  = busAck;
    prevAddr = busAddr;
  end

  task automatic doReset();
    rstN = 1'b0;
    cmdValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // issue one command; returns the cycles from acceptance to req rise
  task automatic issue(input logic wr, input logic [7:0] a,
                       input logic [15:0] d, output int reqLat);
    int n;
    @(negedge clk);
    cmdValid = 1'b1; cmdWrite = wr; cmdAddr = a; cmdWdata = d;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    while (!busReq && n < 50) begin
      @(negedge clk);
      n++;
    end
    reqLat = n;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!cmdDone && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, cmdDone}, 32'd1);
  endtask

  task automatic tResetState();
    check("R1 req", {31'd0, busReq}, 0);
    check("R1 ack", {31'd0, busAck}, 0);
    check("R1 oe", {31'd0, busRdOe}, 0);
    check("R1 done", {31'd0, cmdDone}, 0);
    check("R1 ready", {31'd0, cmdReady}, 1);
    check("R1 rdData", {16'd0, rdData}, 0);
    check("R1 busRdData", {16'd0, busRdData}, 0);
  endtask

  task automatic tWrite(input logic [7:0] a, input logic [15:0] d);
    int lat;
    issue(1'b1, a, d, lat);
    check("R3 decode delay", lat, DEC);
    check("R2 addr", {24'd0, busAddr}, {24'd0, a});
    check("R2 write dir", {31'd0, busWrite}, 1);
    check("R2 wdata", {16'd0, busWdata}, {16'd0, d});
    check("R8 ready low in transfer", {31'd0, cmdReady}, 0);
    waitDone("R8 write done");
    @(negedge clk);
    check("R8 done one cycle", {31'd0, cmdDone}, 0);
  endtask

  task automatic tRead(input logic [7:0] a, input logic [15:0] exp);
    int lat;
    int n = 0;
    issue(1'b0, a, 16'h0, lat);
    check("R3 decode delay rd", lat, DEC);
    check("R2 read dir", {31'd0, busWrite}, 0);
    check("R6 oe low before ack", {31'd0, busRdOe}, 0);
    while (!busAck && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R6 oe with ack", {31'd0, busRdOe}, 1);
    check("R5/R6 bus data", {16'd0, busRdData}, {16'd0, exp});
    waitDone("R8 read done");
    check("R6 rdData captured", {16'd0, rdData}, {16'd0, exp});
    check("R6 bus released", {15'd0, busRdOe, busRdData}, 0);
  endtask

  task automatic tMiss();
    int lat;
    issue(1'b1, 8'h53, 16'hBEEF, lat);
    check("R3 delay on miss", lat, DEC);
    repeat (40) @(negedge clk);
    check("R9 no ack", {31'd0, busAck}, 0);
    check("R9 req pending", {31'd0, busReq}, 1);
    check("R9 ready low", {31'd0, cmdReady}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    doReset();
    tResetState();
    tWrite(8'hA3, 16'h1234);
    tRead(8'hA3, 16'h1234);
    tWrite(8'hA0, 16'hA5A5);
    tWrite(8'hAF, 16'h5A5A);
    tRead(8'hAF, 16'h5A5A);
    tRead(8'hA0, 16'hA5A5);
    tRead(8'hA7, 16'h0000);      // R5: never written word reads zero
    tWrite(8'hA3, 16'hFFFF);
    tRead(8'hA3, 16'hFFFF);
    check("R7 handshake ordering", protoViol, 0);
    check("R2 address held", holdViol, 0);
    tMiss();
    doReset();
    tResetState();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule